// File: doc/BRIEF.md
# Dual-Threshold Window Watchdog Monitor

This block inspects every finished conversion sample and raises a sticky status flag when the value falls outside a window set by a high and a low threshold. Each sample arrives with a 12-bit raw value, a 5-bit channel number and a tag that marks it as belonging to the regular group or the injected group. The comparison uses the raw right-justified value. Any left or right alignment is applied later in the output path and does not affect the comparison.

Checking can be turned on for the regular group and for the injected group independently. In single-channel mode, checking is further limited to one selected channel, and that selection applies to both groups. An interrupt enable gates the sticky flag onto the interrupt request. Software clears the flag with a clear pulse, which stands for writing 0 to the flag. The thresholds and the channel selection can be read back on dedicated ports.

Top module: `win_watch`

## Requirements
- R1: A threshold write stores only bits [11:0] of the 16-bit write data, and the stored value is visible on the readback port one cycle later. Bits above bit 11 are discarded.
- R2: A checked sample counts as a violation when it is strictly greater than the high threshold or strictly less than the low threshold. A sample equal to either threshold does not count as a violation.
- R3: A sample tagged regular (`smp_inj`=0) is checked only while `en_reg` is 1. A sample tagged injected (`smp_inj`=1) is checked only while `en_inj` is 1.
- R4: While both group enables are 0, no sample sets the flag, whatever its value.
- R5: While `single_mode` is 1, only samples whose channel equals the selected channel are checked. While `single_mode` is 0, samples on every channel are checked.
- R6: While `single_mode` is 1 and both group enables are 1, the same selected channel is checked in the regular group and in the injected group.
- R7: A channel-select write with a value above 17 stores 0. A write with a value from 0 to 17 stores that value.
- R8: `irq` is 1 exactly when the flag is 1 and `irq_en` is 1. `irq` follows `irq_en` in the same cycle.
- R9: A violation sets the flag on the next clock edge. The flag stays set until a `flag_clr` pulse, and it reads 0 one cycle after that pulse.
- R10: When a violation and `flag_clr` occur in the same cycle, the flag is 1 after the edge.
- R11: After reset, the flag is 0, the high threshold is 0xFFF, the low threshold is 0 and the selected channel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A finished sample is present this cycle |
| smp_data | input | 12 | Raw right-justified sample value |
| smp_chan | input | 5 | Channel number of the sample |
| smp_inj | input | 1 | 1 = injected group, 0 = regular group |
| hi_wr | input | 1 | Write strobe for the high threshold |
| lo_wr | input | 1 | Write strobe for the low threshold |
| thr_wdata | input | 16 | Threshold write data |
| en_reg | input | 1 | Enable checking of regular samples |
| en_inj | input | 1 | Enable checking of injected samples |
| single_mode | input | 1 | Limit checking to the selected channel |
| sel_wr | input | 1 | Write strobe for the channel select |
| sel_wdata | input | 5 | Channel select write data |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear pulse for the status flag (write of 0) |
| flag | output | 1 | Sticky out-of-window status |
| irq | output | 1 | Interrupt request |
| hi_thr | output | 12 | Stored high threshold |
| lo_thr | output | 12 | Stored low threshold |
| sel_chan | output | 5 | Stored selected channel |

## Verification
Writes to the thresholds and the channel select are stored on one edge, so their readback is due one cycle after the strobe. A violating sample, and equally a clear pulse, takes effect on the flag at the first edge after it is presented, and `irq` follows both the flag and `irq_en` without an extra register. The bench drives every input just after a falling edge and holds it across exactly one rising edge. It then samples outputs at the next falling edge, so each check reads the single registered update that is due. A change to `irq_en` is checked after a short settle delay with no clock edge in between.

// File: rtl/win_watch.sv
module win_watch #(
  parameter int DW     = 12,
  parameter int CW     = 5,
  parameter int WW     = 16,
  parameter int MAX_CH = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic [CW-1:0] smp_chan,
  input  logic          smp_inj,
  input  logic          hi_wr,
  input  logic          lo_wr,
  input  logic [WW-1:0] thr_wdata,
  input  logic          en_reg,
  input  logic          en_inj,
  input  logic          single_mode,
  input  logic          sel_wr,
  input  logic [CW-1:0] sel_wdata,
  input  logic          irq_en,
  input  logic          flag_clr,
  output logic          flag,
  output logic          irq,
  output logic [DW-1:0] hi_thr,
  output logic [DW-1:0] lo_thr,
  output logic [CW-1:0] sel_chan
);

  localparam logic [DW-1:0] HI_RST = {DW{1'b1}};
  localparam logic [CW-1:0] CH_LIM = CW'(MAX_CH);

  logic grp_on, chan_ok, outside, hit;

  assign grp_on  = smp_inj ? en_inj : en_reg;
  assign chan_ok = !single_mode || (smp_chan == sel_chan);
  assign outside = (smp_data > hi_thr) || (smp_data < lo_thr);
  assign hit     = smp_valid && grp_on && chan_ok && outside;
  assign irq     = flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_thr <= HI_RST;
      lo_thr <= '0;
    end else begin
      if (hi_wr) hi_thr <= thr_wdata[DW-1:0];
      if (lo_wr) lo_thr <= thr_wdata[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_chan <= '0;
    else if (sel_wr) sel_chan <= (sel_wdata > CH_LIM) ? '0 : sel_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  AST_HI_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> hi_thr == $past(thr_wdata[DW-1:0])); // R1
  AST_SEL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && sel_wdata > CH_LIM) |=> sel_chan == '0); // R7
  AST_RISE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(smp_valid && (smp_inj ? en_inj : en_reg))); // R3
  AST_RISE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag) && $past(single_mode)) |-> $past(smp_chan == sel_chan)); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag); // R9
  AST_FALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(flag_clr)); // R9
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> !irq); // R8

endmodule

// File: tb/test_win_watch.sv
`timescale 1ns/1ps
module test_win_watch;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, smp_valid, smp_inj, hi_wr, lo_wr, en_reg, en_inj, single_mode;
  logic sel_wr, irq_en, flag_clr, flag, irq;
  logic [11:0] smp_data, hi_thr, lo_thr;
  logic [4:0]  smp_chan, sel_wdata, sel_chan;
  logic [15:0] thr_wdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  win_watch i_win_watch (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_chan(smp_chan), .smp_inj(smp_inj), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .thr_wdata(thr_wdata), .en_reg(en_reg), .en_inj(en_inj),
    .single_mode(single_mode), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .irq_en(irq_en), .flag_clr(flag_clr), .flag(flag), .irq(irq),
    .hi_thr(hi_thr), .lo_thr(lo_thr), .sel_chan(sel_chan)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sample(input logic [11:0] d, input logic [4:0] ch, input logic inj);
    smp_valid = 1'b1; smp_data = d; smp_chan = ch; smp_inj = inj;
    tick();
    smp_valid = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
  endtask

  task automatic write_sel(input logic [4:0] v);
    sel_wr = 1'b1; sel_wdata = v;
    tick();
    sel_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 flag", flag, 0);
    chk("R11 irq", irq, 0);
    chk("R11 hi", hi_thr, 12'hFFF);
    chk("R11 lo", lo_thr, 0);
    chk("R11 sel", sel_chan, 0);
  endtask

  task automatic t_thresholds();
    hi_wr = 1'b1; thr_wdata = 16'hF800; tick(); hi_wr = 1'b0;
    chk("R1 hi masked", hi_thr, 12'h800);
    lo_wr = 1'b1; thr_wdata = 16'h1100; tick(); lo_wr = 1'b0;
    chk("R1 lo masked", lo_thr, 12'h100);
  endtask

  task automatic t_window();
    en_reg = 1'b1;
    sample(12'h800, 5'd3, 1'b0); chk("R2 equal high", flag, 0);
    sample(12'h100, 5'd3, 1'b0); chk("R2 equal low", flag, 0);
    sample(12'h801, 5'd3, 1'b0); chk("R2 above high", flag, 1);
    clear_flag();                chk("R9 clear", flag, 0);
    sample(12'h0FF, 5'd3, 1'b0); chk("R2 below low", flag, 1);
    clear_flag();
  endtask

  task automatic t_sticky();
    sample(12'h900, 5'd1, 1'b0);
    sample(12'h400, 5'd1, 1'b0); chk("R9 sticky", flag, 1);
    tick();                      chk("R9 sticky idle", flag, 1);
    clear_flag();                chk("R9 cleared", flag, 0);
  endtask

  task automatic t_groups();
    en_reg = 1'b1; en_inj = 1'b0;
    sample(12'hFFF, 5'd2, 1'b1); chk("R3 inj gated", flag, 0);
    en_reg = 1'b0; en_inj = 1'b1;
    sample(12'hFFF, 5'd2, 1'b0); chk("R3 reg gated", flag, 0);
    sample(12'hFFF, 5'd2, 1'b1); chk("R3 inj checked", flag, 1);
    clear_flag();
    en_reg = 1'b0; en_inj = 1'b0;
    sample(12'hFFF, 5'd2, 1'b0); chk("R4 none reg", flag, 0);
    sample(12'h000, 5'd2, 1'b1); chk("R4 none inj", flag, 0);
  endtask

  task automatic t_single();
    write_sel(5'd5);
    single_mode = 1'b1; en_reg = 1'b1; en_inj = 1'b0;
    sample(12'hFFF, 5'd4, 1'b0); chk("R5 other chan", flag, 0);
    sample(12'hFFF, 5'd5, 1'b0); chk("R5 sel chan", flag, 1);
    clear_flag();
    single_mode = 1'b0;
    sample(12'hFFF, 5'd4, 1'b0); chk("R5 all chans", flag, 1);
    clear_flag();
    single_mode = 1'b1; en_inj = 1'b1;
    sample(12'hFFF, 5'd5, 1'b1); chk("R6 inj sel", flag, 1);
    clear_flag();
    sample(12'hFFF, 5'd5, 1'b0); chk("R6 reg sel", flag, 1);
    clear_flag();
    sample(12'hFFF, 5'd6, 1'b1); chk("R6 inj other", flag, 0);
    single_mode = 1'b0;
  endtask

  task automatic t_sel();
    write_sel(5'd20); chk("R7 over limit", sel_chan, 0);
    write_sel(5'd17); chk("R7 at limit", sel_chan, 17);
    write_sel(5'd31); chk("R7 max code", sel_chan, 0);
  endtask

  task automatic t_irq();
    en_reg = 1'b1; irq_en = 1'b0;
    sample(12'hFFF, 5'd0, 1'b0);
    chk("R8 masked", irq, 0);
    irq_en = 1'b1; #1;
    chk("R8 enabled", irq, 1);
    clear_flag();
    chk("R8 after clear", irq, 0);
  endtask

  task automatic t_priority();
    sample(12'hFFF, 5'd0, 1'b0);
    flag_clr = 1'b1;
    sample(12'hFFF, 5'd0, 1'b0);
    flag_clr = 1'b0;
    chk("R10 set wins (flag was 1)", flag, 1);
    clear_flag();
    flag_clr = 1'b1;
    sample(12'h000, 5'd0, 1'b0);
    flag_clr = 1'b0;
    chk("R10 set wins (flag was 0)", flag, 1);
    clear_flag();
  endtask

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; smp_chan = '0; smp_inj = 1'b0;
    hi_wr = 1'b0; lo_wr = 1'b0; thr_wdata = '0; en_reg = 1'b0; en_inj = 1'b0;
    single_mode = 1'b0; sel_wr = 1'b0; sel_wdata = '0; irq_en = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_thresholds();
    t_window();
    t_sticky();
    t_groups();
    t_sel();
    t_single();
    t_irq();
    t_priority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule